// File: doc/BRIEF.md
# Dual-Window Bank Address Translator

This block turns a CPU access that lands in the 64 KB graphics aperture (real-mode addresses A0000h to AFFFFh) into an address in a larger linear video memory. Two 7-bit bank registers each hold a base in 4 KB steps. A split bit in a control register chooses the layout of the aperture. With the bit clear, the aperture is one 64 KB window based on the primary bank. With the bit set, it is two 32 KB windows: the lower half uses the primary bank and the upper half uses the secondary bank.

The decode logic is purely combinational. The result is captured in an output register, so the translated address appears one clock after the access. A two-state machine tracks whether the output holds a fresh translation. State `ST_IDLE` moves to `ST_HIT` when a valid access falls inside the aperture. `ST_HIT` stays in `ST_HIT` on another such access and returns to `ST_IDLE` otherwise. `ST_IDLE` stays in `ST_IDLE` when there is no in-aperture access.

A small register port writes the bank and control registers and reads them back. The read port is combinational.

Top module: `bank_window_xlat`

## Requirements
- R1: After reset, `mem_valid` is 0, `mem_addr` is 0, and every register reads back 0.
- R2: Register codes on `reg_addr` are: 0 = primary bank (bits 6:0), 1 = secondary bank (bits 6:0), 2 = control (bit 0 is the split bit; bits 6:1 are stored and read back unchanged). Code 3 reads 0 and ignores writes. `reg_rdata` shows the register chosen by `reg_addr` in the same cycle.
- R3: With split clear, a valid access at address A inside A0000h..AFFFFh produces `mem_addr` = primary*4096 + (A - A0000h).
- R4: With split set, a valid access inside A0000h..A7FFFh produces `mem_addr` = primary*4096 + (A - A0000h).
- R5: With split set, a valid access inside A8000h..AFFFFh produces `mem_addr` = secondary*4096 + (A - A8000h).
- R6: A valid access outside A0000h..AFFFFh gives `mem_valid` = 0 on the next cycle, and `mem_addr` keeps its previous value.
- R7: `mem_valid` is 1 exactly in the cycle after an in-aperture access with `cpu_valid` = 1. When `cpu_valid` is 0, the next cycle has `mem_valid` = 0 and `mem_addr` unchanged.
- R8: An access in the same cycle as a register write is translated with the old register values. An access in the following cycle uses the new values.
- R9: The low 12 bits of `mem_addr` after a valid translation equal the low 12 bits of the access address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select code |
| reg_wdata | input | 7 | Register write data |
| reg_rdata | output | 7 | Register read data (combinational) |
| cpu_valid | input | 1 | Access strobe |
| cpu_addr | input | 20 | CPU real-mode address of the access |
| mem_valid | output | 1 | Translated address is valid this cycle |
| mem_addr | output | 20 | Translated linear video-memory address |

## Verification
A corrupted bank or split register shows up in `reg_rdata` in the same cycle and in `mem_addr` one cycle after the next in-aperture access. A wrong translation is visible above bit 11 of the address. A state machine stuck in `ST_HIT` shows a stale `mem_valid` one cycle after an idle or out-of-aperture cycle. Because every access is compared to a model of the shadow registers, any such fault is reported at the first access that exposes it.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

    typedef enum logic [1:0] {
        RA_LOW  = 2'd0,
        RA_HIGH = 2'd1,
        RA_CTRL = 2'd2,
        RA_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HIT  = 1'b1
    } out_state_e;

endpackage

// File: rtl/bwx_regs.sv
module bwx_regs
    import bwx_pkg::*;
#(
    parameter int BANK_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] rdata,
    output logic [BANK_W-1:0] bank_lo,
    output logic [BANK_W-1:0] bank_hi,
    output logic              split_en
);

    logic [BANK_W-1:0] ctrl_q;
    reg_sel_e          sel;

    assign sel      = reg_sel_e'(addr);
    assign split_en = ctrl_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_lo <= '0;
            bank_hi <= '0;
            ctrl_q  <= '0;
        end else if (we) begin
            unique case (sel)
                RA_LOW:  bank_lo <= wdata;
                RA_HIGH: bank_hi <= wdata;
                RA_CTRL: ctrl_q  <= wdata;
                RA_NONE: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            RA_LOW:  rdata = bank_lo;
            RA_HIGH: rdata = bank_hi;
            RA_CTRL: rdata = ctrl_q;
            RA_NONE: rdata = '0;
        endcase
    end

    // R2: a write to the primary bank is visible the next cycle
    a_r2_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == RA_LOW) |=> (bank_lo == $past(wdata)));

    // R2: the unused code changes no register
    a_r2_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == RA_NONE) |=> ($stable(bank_lo) && $stable(bank_hi) && $stable(ctrl_q)));

endmodule

// File: rtl/bwx_decode.sv
module bwx_decode #(
    parameter int CPU_W    = 20,
    parameter int OUT_W    = 20,
    parameter int BANK_W   = 7,
    parameter int GRAN_W   = 12,
    parameter int APER_W   = 16,
    parameter int APER_TAG = 'hA
) (
    input  logic [CPU_W-1:0]  cpu_addr,
    input  logic [BANK_W-1:0] bank_lo,
    input  logic [BANK_W-1:0] bank_hi,
    input  logic              split_en,
    output logic              in_aperture,
    output logic [OUT_W-1:0]  lin_addr
);

    localparam int TAG_W  = CPU_W - APER_W;
    localparam int HALF_W = APER_W - 1;
    localparam logic [TAG_W-1:0] TAG = APER_TAG[TAG_W-1:0];

    logic              upper_half;
    logic [BANK_W-1:0] bank_sel;
    logic [APER_W-1:0] win_off;

    assign in_aperture = (cpu_addr[CPU_W-1:APER_W] == TAG);
    assign upper_half  = cpu_addr[APER_W-1];
    assign bank_sel    = (split_en && upper_half) ? bank_hi : bank_lo;
    // in split mode the upper half re-bases at its own window start
    assign win_off     = {upper_half & ~split_en, cpu_addr[HALF_W-1:0]};
    assign lin_addr    = (OUT_W'(bank_sel) << GRAN_W) + OUT_W'(win_off);

endmodule

// File: rtl/bwx_out.sv
module bwx_out
    import bwx_pkg::*;
#(
    parameter int OUT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [OUT_W-1:0] lin_addr,
    output logic             mem_valid,
    output logic [OUT_W-1:0] mem_addr
);

    out_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = take ? ST_HIT : ST_IDLE;
            ST_HIT:  state_d = take ? ST_HIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    mem_addr <= '0;
        else if (take) mem_addr <= lin_addr;
    end

    assign mem_valid = (state_q == ST_HIT);

    // R7: an accepted access yields a valid output one cycle later
    a_r7_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> mem_valid);

    // R6 and R7: no accepted access means no valid output and a held address
    a_r6_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> (!mem_valid && $stable(mem_addr)));

endmodule

// File: rtl/bank_window_xlat.sv
module bank_window_xlat #(
    parameter int CPU_W  = 20,
    parameter int OUT_W  = 20,
    parameter int BANK_W = 7,
    parameter int GRAN_W = 12,
    parameter int APER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [BANK_W-1:0] reg_wdata,
    output logic [BANK_W-1:0] reg_rdata,
    input  logic              cpu_valid,
    input  logic [CPU_W-1:0]  cpu_addr,
    output logic              mem_valid,
    output logic [OUT_W-1:0]  mem_addr
);

    logic [BANK_W-1:0] bank_lo, bank_hi;
    logic              split_en, in_ap;
    logic [OUT_W-1:0]  lin_addr;
    logic              take;

    bwx_regs #(.BANK_W(BANK_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .bank_lo  (bank_lo),
        .bank_hi  (bank_hi),
        .split_en (split_en)
    );

    bwx_decode #(
        .CPU_W  (CPU_W),
        .OUT_W  (OUT_W),
        .BANK_W (BANK_W),
        .GRAN_W (GRAN_W),
        .APER_W (APER_W)
    ) u_decode (
        .cpu_addr    (cpu_addr),
        .bank_lo     (bank_lo),
        .bank_hi     (bank_hi),
        .split_en    (split_en),
        .in_aperture (in_ap),
        .lin_addr    (lin_addr)
    );

    assign take = cpu_valid && in_ap;

    bwx_out #(.OUT_W(OUT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .lin_addr  (lin_addr),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr)
    );

    // R9: offset within a 4 KB page passes through unchanged
    a_r9_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (mem_addr[GRAN_W-1:0] == $past(cpu_addr[GRAN_W-1:0])));

    // R6: an out-of-aperture access never produces a valid output
    a_r6_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !in_ap) |=> !mem_valid);

endmodule

// File: tb/bank_window_xlat_tb.sv
`timescale 1ns/1ps
module bank_window_xlat_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [6:0]  reg_wdata;
    logic [6:0]  reg_rdata;
    logic        cpu_valid;
    logic [19:0] cpu_addr;
    logic        mem_valid;
    logic [19:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [6:0]  sh_lo, sh_hi, sh_ctrl;
    logic [19:0] exp_addr;

    always #4 clk = ~clk;

    bank_window_xlat u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpu_valid (cpu_valid),
        .cpu_addr  (cpu_addr),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] shadow_read(input logic [1:0] a);
        case (a)
            2'd0:    return sh_lo;
            2'd1:    return sh_hi;
            2'd2:    return sh_ctrl;
            default: return 7'd0;
        endcase
    endfunction

    function automatic bit in_ap(input logic [19:0] a);
        return a[19:16] == 4'hA;
    endfunction

    function automatic logic [19:0] model_xlat(input logic [19:0] a);
        logic [19:0] off;
        off = {4'h0, a[15:0]};
        if (sh_ctrl[0] && a[15]) return {1'b0, sh_hi, 12'h000} + (off - 20'h08000);
        return {1'b0, sh_lo, 12'h000} + off;
    endfunction

    // one cycle: drive, check the read port, clock, check the output
    task automatic step(input bit we, input logic [1:0] ra, input logic [6:0] wd,
                        input bit v, input logic [19:0] ca, input string req);
        bit exp_v;
        reg_we = we; reg_addr = ra; reg_wdata = wd; cpu_valid = v; cpu_addr = ca;
        #1;
        check(reg_rdata == shadow_read(ra), "R2 readback", 32'(reg_rdata), 32'(shadow_read(ra)));
        exp_v = v && in_ap(ca);
        if (exp_v) exp_addr = model_xlat(ca);   // old registers: R8
        @(posedge clk);
        if (we) begin
            case (ra)
                2'd0: sh_lo = wd;
                2'd1: sh_hi = wd;
                2'd2: sh_ctrl = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        check(mem_valid == exp_v, {req, " valid"}, 32'(mem_valid), 32'(exp_v));
        check(mem_addr == exp_addr, {req, " addr"}, 32'(mem_addr), 32'(exp_addr));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1bad5eed;
        void'($urandom(seed));
        rst_n = 1'b0; reg_we = 0; reg_addr = 0; reg_wdata = 0; cpu_valid = 0; cpu_addr = 0;
        sh_lo = 0; sh_hi = 0; sh_ctrl = 0; exp_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(mem_valid == 1'b0, "R1 valid", 32'(mem_valid), 0);
        check(mem_addr == 20'h0, "R1 addr", 32'(mem_addr), 0);
        for (int i = 0; i < 4; i++) begin
            reg_addr = 2'(i); #1;
            check(reg_rdata == 7'h0, "R1 regs", 32'(reg_rdata), 0);
        end
        // R2: code 3 ignores writes, all registers keep 0
        step(1, 2'd3, 7'h7F, 0, 20'h0, "R2");
        for (int i = 0; i < 3; i++) step(0, 2'(i), 7'h0, 0, 20'h0, "R2");
        // R3: unsplit full window, top of bank range
        step(1, 2'd0, 7'h7F, 0, 20'h0, "R3");
        step(0, 2'd0, 7'h0, 1, 20'hAFFFF, "R3");
        check(mem_addr == 20'h8EFFF, "R3 corner", 32'(mem_addr), 32'h8EFFF);
        step(0, 2'd0, 7'h0, 1, 20'hA8000, "R3");
        step(0, 2'd0, 7'h0, 1, 20'hA0000, "R3");
        // R4 and R5: split windows
        step(1, 2'd0, 7'h12, 0, 20'h0, "R4");
        step(1, 2'd1, 7'h55, 0, 20'h0, "R5");
        step(1, 2'd2, 7'h41, 0, 20'h0, "R2 ctrl");
        step(0, 2'd2, 7'h0, 1, 20'hA7FFF, "R4");
        check(mem_addr == 20'h19FFF, "R4 corner", 32'(mem_addr), 32'h19FFF);
        step(0, 2'd1, 7'h0, 1, 20'hA8000, "R5");
        check(mem_addr == 20'h55000, "R5 corner", 32'(mem_addr), 32'h55000);
        step(0, 2'd1, 7'h0, 1, 20'hAFFFF, "R5");
        // R6: just outside both edges; R7: idle cycle
        step(0, 2'd0, 7'h0, 1, 20'hB0000, "R6");
        step(0, 2'd0, 7'h0, 1, 20'h9FFFF, "R6");
        step(0, 2'd0, 7'h0, 0, 20'hA1234, "R7");
        // R8: write and access in one cycle, then access again
        step(1, 2'd1, 7'h03, 1, 20'hA9ABC, "R8 same cycle");
        step(0, 2'd1, 7'h0, 1, 20'hA9ABC, "R8 next cycle");
        step(1, 2'd2, 7'h00, 1, 20'hA9ABC, "R8 split off");
        step(0, 2'd2, 7'h0, 1, 20'hA9ABC, "R8 unsplit");
        // random mix covering R2 through R9
        for (int n = 0; n < 3000; n++) begin
            logic [19:0] a;
            bit w;
            w = ($urandom % 6) == 0;
            a = ($urandom % 4 != 0) ? {4'hA, 16'($urandom)} : 20'($urandom);
            step(w, 2'($urandom), 7'($urandom), ($urandom % 5) != 0, a, "R9 random");
            if (mem_valid)
                check(mem_addr[11:0] == a[11:0], "R9 page", 32'(mem_addr[11:0]), 32'(a[11:0]));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule